// File: doc/BRIEF.md
# Phase-0 SPI Master Shift Engine

This block is the master side of a serial peripheral link that uses the phase-0 timing. Data goes out on the first clock edge of each bit period and is captured on the second. A single-cycle write strobe with a parallel word starts a transfer. The engine pulls the select line low and drives the first data bit at once. After a programmable half-period it begins toggling the serial clock. On every odd clock edge it captures the input line. On every even clock edge it shifts the captured bit into its shift register and presents the next output bit.

The word length can be 8 or 16 bits, and the bit order can be most-significant first or least-significant first. The serial clock's idle level is programmable. That level does not change which edge samples and which edge shifts. The received word is copied to a separate read register only after the last bit is in, so the previous word stays readable for the whole transfer. At that moment a completion flag is raised, and a read strobe clears it. Half a serial period after the last edge, the select line returns high and the engine goes idle.

Top module: `spi_p0_master`

## Requirements
- R1: After reset, `ss_n` is 1, `busy` and `done_flag` are 0 and `rd_data` is 0. While idle, `sck` follows `cpol` one cycle later (0 = low idle, 1 = high idle).
- R2: The first `sck` transition comes exactly H system clock cycles after `ss_n` falls. Every later half-period is also H cycles, where H is `div_half` latched at the start, and a value of 0 acts as 1, so the division is always at least 2.
- R3: A transfer makes exactly 2n transitions on `sck`, with n = 16 when `wide` = 1 and n = 8 when `wide` = 0. `sck` ends at its idle level.
- R4: In the cycle `ss_n` falls, `mosi` already carries the first bit of the written word: bit n-1 when `lsb_first` = 0, bit 0 when `lsb_first` = 1. After that, `mosi` changes only together with an even `sck` transition, presenting the following bits in the same order.
- R5: `miso` is sampled on odd `sck` transitions and shifted in on even ones. The first sampled bit lands in bit n-1 when `lsb_first` = 0, and in bit 0 when `lsb_first` = 1.
- R6: `rd_data` holds its previous value during a transfer. It takes the new word only on the final (2n-th) `sck` transition.
- R7: `done_flag` rises on the final `sck` transition and stays set until `rd_en` is asserted in a cycle with no completion. It is then 0 in the next cycle.
- R8: `ss_n` stays low exactly while `busy` is 1, and it rises H cycles after the final `sck` transition.
- R9: A write strobe while `busy` is 1 is ignored. The data on the link and the received word are unaffected, and no new transfer follows.
- R10: With `wide` = 0, `rd_data[15:8]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Idle level of `sck` |
| lsb_first | input | 1 | 1: least-significant bit first |
| wide | input | 1 | 1: 16-bit word, 0: 8-bit word |
| div_half | input | DIV_W | System cycles per `sck` half-period (0 acts as 1) |
| wr_en | input | 1 | Write strobe; starts a transfer when idle |
| wr_data | input | DATA_W | Word to transmit |
| rd_en | input | 1 | Read strobe; clears `done_flag` |
| rd_data | output | DATA_W | Last received word |
| done_flag | output | 1 | Transfer complete |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults: a 16-bit data path and an 8-bit divider. Half-periods are drawn from 0 to 3, so the minimum division of 2 and the zero-as-one case both come up alongside longer periods. Every mix of idle level, bit order and 8/16-bit width is reached against a behavioural slave. Directed cases cover a write during a transfer and back-to-back transfers that check the read register is held.

// File: rtl/spi_p0_pkg.sv
package spi_p0_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } spi_st_e;

    typedef struct packed {
        logic pol;
        logic lsb;
        logic wide;
    } spi_cfg_t;
endpackage

// File: rtl/spi_p0_div.sv
module spi_p0_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (half == '0) ? '0 : half - 1'b1;
        tick  = run && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_p0_shift.sv
module spi_p0_shift #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              sin,
    input  logic              lsb,
    input  logic              wide,
    output logic [DATA_W-1:0] nxt,
    output logic [DATA_W-1:0] word,
    output logic              out_cur,
    output logic              out_nxt
);
    localparam int NARROW_W = DATA_W / 2;

    function automatic logic pick(input logic [DATA_W-1:0] v, input logic l, input logic w);
        if (l)      return v[0];
        else if (w) return v[DATA_W-1];
        else        return v[NARROW_W-1];
    endfunction

    always_comb begin
        if (lsb) begin
            nxt = cur >> 1;
            if (wide) nxt[DATA_W-1]   = sin;
            else      nxt[NARROW_W-1] = sin;
        end else begin
            nxt = {cur[DATA_W-2:0], sin};
        end
        word    = wide ? nxt : {{(DATA_W-NARROW_W){1'b0}}, nxt[NARROW_W-1:0]};
        out_cur = pick(cur, lsb, wide);
        out_nxt = pick(nxt, lsb, wide);
    end
endmodule

// File: rtl/spi_p0_master.sv
module spi_p0_master
    import spi_p0_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              lsb_first,
    input  logic              wide,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_flag,
    output logic              busy,
    output logic              sck,
    output logic              ss_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int NARROW_W = DATA_W / 2;
    localparam int EDGE_W   = $clog2(2 * DATA_W + 1);
    localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * DATA_W);
    localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(2 * NARROW_W);

    typedef struct packed {
        spi_st_e           st;
        spi_cfg_t          cfg;
        logic [DIV_W-1:0]  half;
        logic [DATA_W-1:0] shreg;
        logic              samp;
        logic [EDGE_W-1:0] edges;
        logic [DATA_W-1:0] rd;
        logic              flag;
        logic              sck;
        logic              ss_n;
        logic              mosi;
    } eng_t;

    eng_t d, q;

    logic              tick;
    logic [DATA_W-1:0] sh_cur, sh_nxt, sh_word;
    logic              sh_lsb, sh_wide, sh_out_cur, sh_out_nxt;
    logic [EDGE_W-1:0] edges_inc;
    logic              set_flag;

    spi_p0_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st != ST_IDLE),
        .half (q.half),
        .tick (tick)
    );

    assign sh_cur  = (q.st == ST_IDLE) ? wr_data   : q.shreg;
    assign sh_lsb  = (q.st == ST_IDLE) ? lsb_first : q.cfg.lsb;
    assign sh_wide = (q.st == ST_IDLE) ? wide      : q.cfg.wide;

    spi_p0_shift #(.DATA_W(DATA_W)) u_shift (
        .cur    (sh_cur),
        .sin    (q.samp),
        .lsb    (sh_lsb),
        .wide   (sh_wide),
        .nxt    (sh_nxt),
        .word   (sh_word),
        .out_cur(sh_out_cur),
        .out_nxt(sh_out_nxt)
    );

    assign edges_inc = q.edges + 1'b1;

    always_comb begin
        d        = q;
        set_flag = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.sck = cpol;
                if (wr_en) begin
                    d.st    = ST_RUN;
                    d.cfg   = '{pol: cpol, lsb: lsb_first, wide: wide};
                    d.half  = div_half;
                    d.shreg = wr_data;
                    d.mosi  = sh_out_cur;
                    d.edges = '0;
                    d.ss_n  = 1'b0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    d.edges = edges_inc;
                    d.sck   = ~q.sck;
                    if (!q.edges[0]) begin
                        d.samp = miso;
                    end else begin
                        d.shreg = sh_nxt;
                        d.mosi  = sh_out_nxt;
                        if (edges_inc == (q.cfg.wide ? LAST_WIDE : LAST_NARROW)) begin
                            d.rd     = sh_word;
                            d.st     = ST_TAIL;
                            set_flag = 1'b1;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.ss_n = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (set_flag)   d.flag = 1'b1;
        else if (rd_en) d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ss_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_data   = q.rd;
    assign done_flag = q.flag;
    assign busy      = (q.st != ST_IDLE);
    assign sck       = q.sck;
    assign ss_n      = q.ss_n;
    assign mosi      = q.mosi;
endmodule

// File: rtl/spi_p0_checker.sv
module spi_p0_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpol,
    input logic              rd_en,
    input logic              busy,
    input logic              sck,
    input logic              ss_n,
    input logic              mosi,
    input logic              done_flag,
    input logic [DATA_W-1:0] rd_data
);
    logic pv_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    assert_idle_sck_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(!busy) && !busy) |-> (sck == $past(cpol)));

    assert_ss_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !ss_n);

    assert_mosi_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $changed(mosi)) |-> ($changed(sck) || $rose(busy)));

    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $changed(rd_data)) |-> (busy && done_flag && $changed(sck)));

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(rd_en) && $past(!busy)) |-> !done_flag);

    assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $rose(done_flag)) |-> ($changed(sck) && busy));
endmodule

bind spi_p0_master spi_p0_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpol     (cpol),
    .rd_en    (rd_en),
    .busy     (busy),
    .sck      (sck),
    .ss_n     (ss_n),
    .mosi     (mosi),
    .done_flag(done_flag),
    .rd_data  (rd_data)
);

// File: tb/sim_spi_p0_master.sv
`timescale 1ns/1ps
module sim_spi_p0_master;
    localparam int DATA_W = 16;
    localparam int DIV_W  = 8;
    localparam int PER    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpol = 1'b0, lsb_first = 1'b0, wide = 1'b0;
    logic [DIV_W-1:0]  div_half = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              done_flag, busy, sck, ss_n, mosi;
    logic              miso = 1'b0;

    int n_chk = 0, n_bad = 0;

    always #(PER/2) clk = ~clk;

    spi_p0_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .lsb_first(lsb_first), .wide(wide),
        .div_half(div_half), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .done_flag(done_flag), .busy(busy), .sck(sck),
        .ss_n(ss_n), .mosi(mosi), .miso(miso)
    );

    // behavioural slave
    logic [15:0] sl_word = '0, sl_got = '0;
    bit          sl_lsb = 1'b0;
    int          sl_n = 8, sl_edges = 0;
    time         t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;

    function automatic int bpos(input int i, input bit l, input int n);
        return l ? i : n - 1 - i;
    endfunction

    always @(negedge ss_n) begin
        sl_edges = 0;
        sl_got   = '0;
        t_fall   = $time;
        miso     = sl_word[bpos(0, sl_lsb, sl_n)];
    end

    always @(posedge ss_n) t_rise = $time;

    always @(sck) begin
        if (ss_n === 1'b0) begin
            sl_edges = sl_edges + 1;
            t_last   = $time;
            if (sl_edges == 1) t_first = $time;
            if (sl_edges % 2 == 1) begin
                if ((sl_edges - 1) / 2 < sl_n) sl_got[bpos((sl_edges - 1) / 2, sl_lsb, sl_n)] = mosi;
            end else if (sl_edges / 2 < sl_n) begin
                miso = sl_word[bpos(sl_edges / 2, sl_lsb, sl_n)];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_xfer(input logic [15:0] m, input logic [15:0] s, input int h,
                            input bit pol, input bit lsb, input bit w, input bit poke);
        int          n    = w ? 16 : 8;
        int          he   = (h == 0) ? 1 : h;
        logic [15:0] mask = w ? 16'hFFFF : 16'h00FF;
        logic [15:0] prev = rd_data;
        bit          first;
        @(negedge clk);
        cpol = pol; lsb_first = lsb; wide = w; div_half = DIV_W'(h);
        sl_word = s; sl_lsb = lsb; sl_n = n;
        @(negedge clk);
        check(sck == pol, "R1 idle sck", 32'(sck), 32'(pol));
        wr_en = 1'b1; wr_data = m;
        @(negedge clk);
        wr_en = 1'b0;
        first = lsb ? m[0] : m[n-1];
        check(ss_n == 1'b0 && busy, "R8 ss_n low", 32'(ss_n), 32'd0);
        check(mosi == first, "R4 first bit", 32'(mosi), 32'(first));
        while (sl_edges < 3) @(negedge clk);
        check(rd_data == prev, "R6 rd held", 32'(rd_data), 32'(prev));
        check(done_flag == 1'b0, "R7 flag low mid-transfer", 32'(done_flag), 32'd0);
        if (poke) begin
            wr_en = 1'b1; wr_data = ~m;
            @(negedge clk);
            wr_en = 1'b0;
        end
        while (busy) @(negedge clk);
        check(sl_edges == 2 * n, "R3 edge count", 32'(sl_edges), 32'(2 * n));
        check(sck == pol, "R3 sck idle after", 32'(sck), 32'(pol));
        check(sl_got == (m & mask), "R4 mosi word", 32'(sl_got), 32'(m & mask));
        check(rd_data == (s & mask), "R5 R10 received word", 32'(rd_data), 32'(s & mask));
        check(done_flag == 1'b1, "R7 flag set", 32'(done_flag), 32'd1);
        check((t_first - t_fall) / PER == he, "R2 lead delay", 32'((t_first - t_fall) / PER), 32'(he));
        check((t_rise - t_last) / PER == he, "R8 tail delay", 32'((t_rise - t_last) / PER), 32'(he));
        repeat (3) @(negedge clk);
        check(ss_n == 1'b1 && !busy, "R9 no restart", 32'(busy), 32'd0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(done_flag == 1'b0, "R7 flag cleared", 32'(done_flag), 32'd0);
        check(rd_data == (s & mask), "R6 rd after read", 32'(rd_data), 32'(s & mask));
    endtask

    initial begin
        #(PER * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(ss_n == 1'b1 && !busy && !done_flag, "R1 reset outputs", 32'({ss_n, busy, done_flag}), 32'h4);
        check(rd_data == 16'h0, "R1 reset rd", 32'(rd_data), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corners
        run_xfer(16'hA5C3, 16'h3C5A, 1, 0, 0, 1, 0);
        run_xfer(16'h00B4, 16'hFF69, 0, 1, 1, 0, 0);
        run_xfer(16'h8001, 16'h7FFE, 3, 1, 0, 1, 1);
        run_xfer(16'h1234, 16'hBEEF, 2, 0, 1, 0, 1);
        // constrained random
        for (int i = 0; i < 30; i++) begin
            logic [15:0] m = 16'($urandom);
            logic [15:0] s = 16'($urandom);
            int  h   = int'($urandom % 4);
            bit  pol = 1'($urandom);
            bit  lsb = 1'($urandom);
            bit  w   = 1'($urandom);
            bit  pk  = ($urandom % 4) == 0;
            run_xfer(m, s, h, pol, lsb, w, pk);
        end
        summary();
    end
endmodule